// File: doc/BRIEF.md
# UV-Erasable PROM Mode Decoder with Identifier Readout

This block is a synthesizable behavioural model of the control side of a 16-bit-wide ultraviolet-erasable PROM. It holds a small array of words whose size is set by a parameter. Each clock it decodes the active-low chip select and output enable, address bit 0, and three digital flags into one operating mode. The flags stand for analog conditions: a supervoltage on the identifier address line, a raised programming supply, and a full-rail standby select.

The modes are read, output disable, standby, program, program verify, program inhibit and identifier readout. The data output and its drive qualifier are registered, so a result appears one clock after the inputs that select it. A program cycle can only clear bits. An erase input returns every word to all ones in one clock. The block is meant to stand in for a boot or table memory in system models and in programmer-flow tests.

Top module: `uvprom_ctrl`

## Requirements
- R1: After reset every word reads back as 16'hFFFF.
- R2: With `ce_n`=0, `oe_n`=0, `id_hv`=0 and `sby_deep`=0, `dq_oe` is 1 and `dq_out` is the addressed word one clock later. This holds whatever the value of `vpp_hi`.
- R3: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, `dq_oe` is 0 one clock later and no word changes.
- R4: With `ce_n`=1 and `vpp_hi`=0, `dq_oe` is 0 one clock later whatever the value of `oe_n`.
- R5: With `sby_deep`=1, `dq_oe` is 0 one clock later and no word changes, whatever the other inputs are.
- R6: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=1, the addressed word becomes (old word AND `din`) at that clock edge, and `dq_oe` is 0 one clock later.
- R7: With `vpp_hi`=1, `ce_n`=1 and `oe_n`=0, `dq_oe` is 1 and `dq_out` is the addressed word one clock later.
- R8: With `vpp_hi`=1, `ce_n`=1 and `oe_n`=1, `dq_oe` is 0 one clock later and no word changes.
- R9: With `id_hv`=1, `ce_n`=0, `oe_n`=0 and all address bits above bit 0 low, `dq_out` is 16'h0001 when address bit 0 is 0 and 16'h0019 when it is 1. `dq_oe` is 1 in both cases. Bits 15:8 are zero, and bit 7 makes the ones count of bits 7:0 odd.
- R10: In identifier mode with any address bit above bit 0 set, `dq_oe` is 1 and `dq_out` is 16'h0000.
- R11: A clock with `erase`=1 sets every word to 16'hFFFF.
- R12: When `erase`=1 falls in the same clock as a program cycle, the erase wins and the addressed word ends as 16'hFFFF.
- R13: Whenever `dq_oe` is 0, `dq_out` is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip select and program strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| id_hv | input | 1 | Supervoltage present on the identifier address line |
| vpp_hi | input | 1 | Programming supply raised |
| sby_deep | input | 1 | Full-rail standby select |
| erase | input | 1 | Whole-array erase to all ones |
| addr | input | AW | Word address |
| din | input | 16 | Data to program |
| dq_out | output | 16 | Registered read data |
| dq_oe | output | 1 | Registered output drive enable |

## Verification
Two functions can fall in the same cycle: a whole-array erase and a program pulse. The bench provokes this by first clearing a word to a known pattern. It then programs that word with zeros while `erase` is high in the same clock. The outcome is judged by reading the word back, and by reading several other words, all of which must show 16'hFFFF.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

  typedef enum logic [2:0] {
    M_STBY,
    M_READ,
    M_ODIS,
    M_PROG,
    M_VRFY,
    M_INHB,
    M_IDRD
  } prom_mode_t;

  // Put an odd-parity bit in bit 7 above a 7-bit identifier value.
  function automatic logic [7:0] odd_par8(input logic [6:0] v);
    return {~(^v), v};
  endfunction

endpackage

// File: rtl/uvprom_decode.sv
module uvprom_decode
  import uvprom_pkg::*;
(
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       id_hv,
  input  logic       vpp_hi,
  input  logic       sby_deep,
  output prom_mode_t mode
);

  always_comb begin
    if (sby_deep) begin
      mode = M_STBY;
    end else if (ce_n) begin
      if (vpp_hi) mode = oe_n ? M_INHB : M_VRFY;
      else        mode = M_STBY;
    end else if (oe_n) begin
      mode = vpp_hi ? M_PROG : M_ODIS;
    end else if (id_hv) begin
      mode = M_IDRD;
    end else begin
      mode = M_READ;
    end
  end

endmodule

// File: rtl/uvprom_array.sv
module uvprom_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          erase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rword
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];
  logic [DW-1:0] cell_d [DEPTH];
  logic [DEPTH-1:0] cell_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_comb begin
      cell_en[g] = erase || (wr_en && (addr == AW'(g)));
      cell_d[g]  = erase ? {DW{1'b1}} : (cell_q[g] & wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cell_q[g] <= {DW{1'b1}};
      else if (cell_en[g]) cell_q[g] <= cell_d[g];
    end
  end

  assign rword = cell_q[addr];

endmodule

// File: rtl/uvprom_idrom.sv
module uvprom_idrom
  import uvprom_pkg::*;
#(
  parameter int          AW     = 6,
  parameter int          DW     = 16,
  parameter logic [6:0]  MFR_ID = 7'h01,
  parameter logic [6:0]  DEV_ID = 7'h19
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] id_word
);

  localparam logic [7:0] MFR_BYTE = odd_par8(MFR_ID);
  localparam logic [7:0] DEV_BYTE = odd_par8(DEV_ID);

  logic legal;

  always_comb begin
    legal = (addr[AW-1:1] == '0);
    if (!legal)       id_word = '0;
    else if (addr[0]) id_word = {{(DW-8){1'b0}}, DEV_BYTE};
    else              id_word = {{(DW-8){1'b0}}, MFR_BYTE};
  end

endmodule

// File: rtl/uvprom_ctrl.sv
module uvprom_ctrl
  import uvprom_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          id_hv,
  input  logic          vpp_hi,
  input  logic          sby_deep,
  input  logic          erase,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   din,
  output logic [15:0]   dq_out,
  output logic          dq_oe
);

  localparam int DW = 16;

  prom_mode_t    mode;
  logic [DW-1:0] rword;
  logic [DW-1:0] id_word;
  logic          wr_en;
  logic [DW-1:0] dq_d;
  logic          oe_d;

  uvprom_decode u_dec (
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .id_hv    (id_hv),
    .vpp_hi   (vpp_hi),
    .sby_deep (sby_deep),
    .mode     (mode)
  );

  assign wr_en = (mode == M_PROG);

  uvprom_array #(.AW(AW), .DW(DW)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .erase (erase),
    .addr  (addr),
    .wdata (din),
    .rword (rword)
  );

  uvprom_idrom #(.AW(AW), .DW(DW)) u_id (
    .addr    (addr),
    .id_word (id_word)
  );

  always_comb begin
    oe_d = 1'b0;
    dq_d = '0;
    case (mode)
      M_READ, M_VRFY: begin
        oe_d = 1'b1;
        dq_d = rword;
      end
      M_IDRD: begin
        oe_d = 1'b1;
        dq_d = id_word;
      end
      default: begin
        oe_d = 1'b0;
        dq_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= oe_d;
      dq_out <= dq_d;
    end
  end

endmodule

// File: rtl/uvprom_chk.sv
module uvprom_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          id_hv,
  input logic          vpp_hi,
  input logic          sby_deep,
  input logic [AW-1:0] addr,
  input logic [15:0]   dq_out,
  input logic          dq_oe
);

  // R13
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == 16'h0000);

  // R5
  deep_sby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sby_deep)) |-> !dq_oe);

  // R4
  standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ce_n) && !$past(vpp_hi)) |-> !dq_oe);

  // R3
  out_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ce_n) && $past(oe_n) && !$past(vpp_hi)) |-> !dq_oe);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ce_n) && !$past(oe_n) && !$past(id_hv) && !$past(sby_deep))
    |-> dq_oe);

  // R8
  inhibit_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ce_n) && $past(oe_n) && $past(vpp_hi)) |-> !dq_oe);

  // R9
  id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ce_n) && !$past(oe_n) && $past(id_hv) && !$past(sby_deep)
     && ($past(addr) >> 1) == '0)
    |-> (dq_oe && dq_out[15:8] == 8'h00 && ($countones(dq_out[7:0]) % 2) == 1));

  // R10
  id_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ce_n) && !$past(oe_n) && $past(id_hv) && !$past(sby_deep)
     && ($past(addr) >> 1) != '0)
    |-> (dq_oe && dq_out == 16'h0000));

endmodule

bind uvprom_ctrl uvprom_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .id_hv    (id_hv),
  .vpp_hi   (vpp_hi),
  .sby_deep (sby_deep),
  .addr     (addr),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe)
);

// File: tb/uvprom_ctrl_tb.sv
module uvprom_ctrl_tb;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          ce_n, oe_n, id_hv, vpp_hi, sby_deep, erase;
  logic [AW-1:0] addr;
  logic [15:0]   din;
  logic [15:0]   dq_out;
  logic          dq_oe;

  logic [15:0] model [DEPTH];
  int n_chk;
  int n_bad;

  uvprom_ctrl #(.AW(AW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .id_hv    (id_hv),
    .vpp_hi   (vpp_hi),
    .sby_deep (sby_deep),
    .erase    (erase),
    .addr     (addr),
    .din      (din),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic exp_oe, input logic [15:0] exp_dq);
    n_chk++;
    if (dq_oe !== exp_oe || dq_out !== exp_dq) begin
      n_bad++;
      $display("FAIL %s: got oe=%0b dq=%04h, expected oe=%0b dq=%04h",
               req, dq_oe, dq_out, exp_oe, exp_dq);
    end
  endtask

  // Apply inputs at the falling edge, let one rising edge pass,
  // and return at the next falling edge.
  task automatic step(input logic c, input logic o, input logic h, input logic v,
                      input logic s, input logic e, input logic [AW-1:0] a,
                      input logic [15:0] w);
    ce_n = c; oe_n = o; id_hv = h; vpp_hi = v; sby_deep = s; erase = e;
    addr = a; din = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int i, input int k);
    return 16'((i * 16'h0109 + k * 16'h3C5B) ^ (16'hA5A5 >> k));
  endfunction

  function automatic logic [7:0] odd_byte(input logic [6:0] v);
    return {~(^v), v};
  endfunction

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    ce_n = 1; oe_n = 1; id_hv = 0; vpp_hi = 0; sby_deep = 0; erase = 0;
    addr = '0; din = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R13 reset", 1'b0, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: erased contents after reset
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, 0, 0, 0, AW'(i), 16'h0);
      check("R1", 1'b1, 16'hFFFF);
    end

    // R6 then R2: two program passes, second may only clear bits
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < DEPTH; i++) begin
        step(0, 1, 0, 1, 0, 0, AW'(i), pat(i, k));
        model[i] = model[i] & pat(i, k);
        check("R6 float", 1'b0, 16'h0000);
      end
      for (int i = 0; i < DEPTH; i++) begin
        step(0, 0, 0, k[0], 0, 0, AW'(i), 16'h0);
        check("R6 R2 readback", 1'b1, model[i]);
      end
    end

    // R7: verify mode drives stored word
    for (int i = 0; i < DEPTH; i += 5) begin
      step(1, 0, 0, 1, 0, 0, AW'(i), 16'h0);
      check("R7", 1'b1, model[i]);
    end

    // R3, R4, R5, R8: floating modes with writes offered, contents untouched
    for (int i = 0; i < 8; i++) begin
      step(0, 1, 0, 0, 0, 0, AW'(i), 16'h0000);
      check("R3", 1'b0, 16'h0000);
      step(1, i[0], 0, 0, 0, 0, AW'(i), 16'h0000);
      check("R4", 1'b0, 16'h0000);
      step(i[0], i[1], i[2], 1, 1, 0, AW'(i), 16'h0000);
      check("R5", 1'b0, 16'h0000);
      step(1, 1, 0, 1, 0, 0, AW'(i), 16'h0000);
      check("R8", 1'b0, 16'h0000);
      step(0, 0, 0, 0, 0, 0, AW'(i), 16'h0);
      check("R3 R5 R8 unchanged", 1'b1, model[i]);
    end

    // R9: identifier codes
    step(0, 0, 1, 0, 0, 0, AW'(0), 16'h0);
    check("R9 mfr", 1'b1, {8'h00, odd_byte(7'h01)});
    step(0, 0, 1, 1, 0, 0, AW'(1), 16'h0);
    check("R9 dev", 1'b1, {8'h00, odd_byte(7'h19)});
    check("R9 dev value", 1'b1, 16'h0019);

    // R10: illegal identifier addresses
    for (int i = 2; i < DEPTH; i += 3) begin
      step(0, 0, 1, 0, 0, 0, AW'(i), 16'h0);
      check("R10", 1'b1, 16'h0000);
    end

    // R11: erase restores all ones
    step(1, 1, 0, 0, 0, 1, AW'(0), 16'h0);
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, 0, 0, 0, AW'(i), 16'h0);
      check("R11", 1'b1, 16'hFFFF);
    end

    // R12: erase and program in the same clock
    step(0, 1, 0, 1, 0, 0, AW'(9), 16'h1234);
    step(0, 0, 0, 0, 0, 0, AW'(9), 16'h0);
    check("R12 setup", 1'b1, 16'h1234);
    step(0, 1, 0, 1, 0, 1, AW'(9), 16'h0000);
    check("R12 float", 1'b0, 16'h0000);
    for (int i = 7; i < 12; i++) begin
      step(0, 0, 0, 0, 0, 0, AW'(i), 16'h0);
      check("R12", 1'b1, 16'hFFFF);
    end

    // R13: one-cycle latency, bus quiet right after a read ends
    step(0, 0, 0, 0, 0, 0, AW'(3), 16'h0);
    ce_n = 1;
    #1;
    check("R13 hold", 1'b1, 16'hFFFF);
    @(posedge clk);
    @(negedge clk);
    check("R13 quiet", 1'b0, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule